// File: doc/BRIEF.md
# Periodic Skip Symbol Inserter

This block sits on the transmit path of a serial link, in the local clock domain, directly in front of the line encoder. The application offers symbols through a valid/ready handshake, each an 8-bit value plus a control flag that marks it as a special (K) code. The block puts out exactly one symbol on every clock, because a serial line cannot pause. When the application has nothing to send, an idle filler symbol goes out instead.

A receiver whose clock runs a few ppm slower than the sender's would slowly fill its elastic buffer. To prevent this, the block holds off the application on a fixed cadence and inserts a pair of skip control symbols. The receiver discards these symbols, which gives it time to catch up. The cadence is a parameter counted in symbol slots. It must be short enough to absorb a combined offset of 20 ppm between the two oscillators.

Top module: `skip_inserter`

## Requirements
- R1: While `rst_n` is low, the output is the idle symbol (`out_data` = 0xBC, `out_ctrl` = 1). After release, `in_ready` is high in the first slot, and the interval count starts from zero.
- R2: A symbol accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data`/`out_ctrl` right after that edge, unchanged, whatever its value. This includes the byte values 0x3C and 0xBC with the control flag set.
- R3: In a slot where `in_ready` is high and `in_valid` is low, the symbol emitted after the edge is the idle symbol: byte 0xBC with the control flag at 1.
- R4: After every INTERVAL ordinary slots (data or idle), counted from reset or from the end of the last skip pair, two skip symbols follow on consecutive clocks. A skip symbol is byte 0x3C with the control flag at 1. The cadence therefore repeats every INTERVAL+2 slots.
- R5: `in_ready` is low in exactly the two skip slots and high in all other slots. A symbol offered while `in_ready` is low is neither emitted nor lost. It goes out in the first slot after the pair, provided the application holds it.
- R6: Idle slots advance the interval count exactly as data slots do.
- R7: Asserting `rst_n` low in the middle of a run forces the idle symbol at once. After release, the cadence restarts from zero.
- R8: A skip pair is never split. Once `in_ready` falls, it stays low for the next clock as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Application offers a symbol |
| in_data | input | 8 | Offered symbol byte |
| in_ctrl | input | 1 | Offered symbol is a control code |
| in_ready | output | 1 | Block accepts the offered symbol this cycle |
| out_data | output | 8 | Emitted symbol byte, one per clock |
| out_ctrl | output | 1 | Emitted symbol is a control code |

## Verification
`in_ready` depends only on the slot state, so it is due in the same cycle as the slot it describes. The bench compares it before the clock edge that ends the slot. The emitted symbol passes through one output register, so the symbol chosen in a slot is due right after the edge that closes that slot. The bench samples it at the following falling edge. The expected symbol comes from the slot index modulo INTERVAL+2 together with whatever the bench offered in that slot. The asynchronous reset is checked one time step after it is asserted, with no clock edge in between.

// File: rtl/skip_pkg.sv
package skip_pkg;

  typedef struct packed {
    logic       ctrl;
    logic [7:0] data;
  } sym_t;

  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_TAIL = 1'b1
  } phase_e;

  localparam sym_t SYM_SKIP = '{ctrl: 1'b1, data: 8'h3C};
  localparam sym_t SYM_IDLE = '{ctrl: 1'b1, data: 8'hBC};

endpackage

// File: rtl/skip_cadence.sv
// Slot counter: INTERVAL ordinary slots, then two skip slots, repeat.
module skip_cadence
  import skip_pkg::*;
#(
  parameter int unsigned INTERVAL = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic skip_slot
);

  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INTERVAL);

  logic [CW-1:0] cnt_q, cnt_d;
  phase_e        phase_q, phase_d;
  logic          cnt_en;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b1;
    skip_slot = 1'b0;
    if (phase_q == PH_TAIL) begin
      skip_slot = 1'b1;
      phase_d   = PH_RUN;
      cnt_d     = '0;
    end else if (cnt_q == LIMIT) begin
      skip_slot = 1'b1;
      phase_d   = PH_TAIL;
      cnt_en    = 1'b0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en || phase_q == PH_TAIL) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/skip_sym_sel.sv
// Chooses the symbol for the current slot.
module skip_sym_sel
  import skip_pkg::*;
(
  input  logic skip_slot,
  input  logic in_valid,
  input  sym_t in_sym,
  output sym_t next_sym
);

  always_comb begin
    if (skip_slot)     next_sym = SYM_SKIP;
    else if (in_valid) next_sym = in_sym;
    else               next_sym = SYM_IDLE;
  end

endmodule

// File: rtl/skip_inserter.sv
module skip_inserter
  import skip_pkg::*;
#(
  parameter int unsigned INTERVAL = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_ctrl,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_ctrl
);

  logic skip_slot;
  sym_t in_sym, next_sym, out_q;

  skip_cadence #(.INTERVAL(INTERVAL)) u_cadence (
    .clk      (clk),
    .rst_n    (rst_n),
    .skip_slot(skip_slot)
  );

  assign in_sym = '{ctrl: in_ctrl, data: in_data};

  skip_sym_sel u_sel (
    .skip_slot(skip_slot),
    .in_valid (in_valid),
    .in_sym   (in_sym),
    .next_sym (next_sym)
  );

  // Line never stalls: output register loads on every clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= SYM_IDLE;
    else        out_q <= next_sym;
  end

  assign in_ready = !skip_slot;
  assign out_data = out_q.data;
  assign out_ctrl = out_q.ctrl;

endmodule

// File: rtl/skip_inserter_chk.sv
module skip_inserter_chk #(
  parameter int unsigned INTERVAL = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ctrl,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_ctrl
);

  // Consecutive ready-high slots seen before the current one.
  logic [31:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (in_ready) run_q <= run_q + 32'd1;
    else               run_q <= '0;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_data == $past(in_data) && out_ctrl == $past(in_ctrl));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> out_ctrl && out_data == 8'hBC);

  p_skip_sym_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_ctrl && out_data == 8'h3C);

  p_cadence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> run_q < INTERVAL);

  p_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q == INTERVAL |-> !in_ready);

  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && $past(!in_ready) |=> in_ready);

  p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |=> !in_ready);

endmodule

bind skip_inserter skip_inserter_chk #(.INTERVAL(INTERVAL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_data (in_data),
  .in_ctrl (in_ctrl),
  .in_ready(in_ready),
  .out_data(out_data),
  .out_ctrl(out_ctrl)
);

// File: tb/tb_skip_inserter.sv
module tb_skip_inserter;

  localparam int IV = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ctrl;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_ctrl;

  int  vecs = 0;
  int  errs = 0;
  int  slot = 0;
  bit  done = 1'b0;
  bit  cur_v = 1'b0;
  logic [7:0] cur_d = 8'h00;
  bit  cur_c = 1'b0;

  always #10 clk = ~clk;

  skip_inserter #(.INTERVAL(IV)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .in_ready(in_ready), .out_data(out_data), .out_ctrl(out_ctrl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_skip_slot(input int s);
    return (s % (IV + 2)) >= IV;
  endfunction

  // One slot: inputs driven from cur_*, checked at falling edges.
  task automatic run_slot(output bit accepted);
    bit         skip;
    logic [8:0] exp;
    string      req;
    in_valid = cur_v; in_data = cur_d; in_ctrl = cur_c;
    #1;
    skip = is_skip_slot(slot);
    chk(in_ready == !skip, skip ? "R5" : "R4", "in_ready", in_ready, !skip);
    if (skip)       begin exp = {1'b1, 8'h3C}; req = "R4"; end
    else if (cur_v) begin exp = {cur_c, cur_d}; req = "R2"; end
    else            begin exp = {1'b1, 8'hBC}; req = "R3"; end
    accepted = cur_v && !skip;
    @(negedge clk);
    chk({out_ctrl, out_data} == exp, req, "out symbol", {out_ctrl, out_data}, exp);
    slot++;
  endtask

  task automatic new_word(input int mode);
    case (mode)
      0:       cur_v = 1'b1;
      1:       cur_v = 1'b0;
      2:       cur_v = ($urandom % 2) == 0;
      default: cur_v = ($urandom % 4) == 0;
    endcase
    cur_d = 8'($urandom);
    cur_c = ($urandom % 8) == 0;
  endtask

  task automatic run(input int mode, input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      run_slot(acc);
      if (acc || !cur_v) new_word(mode);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit acc;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_ctrl = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle symbol held during reset
    chk(out_ctrl && out_data == 8'hBC, "R1", "reset out", {out_ctrl, out_data}, 9'h1BC);
    rst_n = 1'b1;
    slot = 0;

    // R5: application always valid; held word survives each skip pair
    new_word(0);
    run(0, 2 * (IV + 2) + 3);

    // R6: idle-only stretch keeps the cadence
    cur_v = 1'b0;
    run(1, IV + 5);

    // R2: control code values equal to skip and idle pass through unchanged
    cur_v = 1'b1; cur_d = 8'h3C; cur_c = 1'b1;
    run_slot(acc);
    cur_v = 1'b1; cur_d = 8'hBC; cur_c = 1'b1;
    run_slot(acc);
    cur_v = 1'b1; cur_d = 8'h3C; cur_c = 1'b0;
    run_slot(acc);
    new_word(2);

    run(2, 300);

    // R7: reset in the middle of an interval
    while ((slot % (IV + 2)) != 5) run(2, 1);
    rst_n = 1'b0;
    #1;
    chk(out_ctrl && out_data == 8'hBC, "R7", "async reset out",
        {out_ctrl, out_data}, 9'h1BC);
    @(negedge clk);
    rst_n = 1'b1;
    slot = 0;
    run(3, 200);
    run(0, 40);

    summary();
  end

endmodule